// File: doc/BRIEF.md
# Byte Stream Datagram Packetizer

This block turns a stream of single bytes into whole datagram payloads. The byte producer sees a port that acts like a serial transmitter: it presents a byte, pulses a write strobe, and holds off while a busy flag is high. Every byte carries one extra tag bit, the flush flag. The block stores the data bits and the tag together in a small 9-bit queue. It collects the bytes into a payload and closes the payload when one of two things happens: the payload reaches its maximum size, or a byte tagged with flush arrives. A tagged byte is kept as the final byte of the payload it closes.

A closed payload is held in full in one of two ping-pong banks before its first beat leaves the block. This lets the length count be shown, correct, from the first beat. While one bank drains downstream, the other keeps filling. The output is a valid/ready byte stream with a last marker and a payload length. A programmable gap input sets a minimum number of idle cycles after each payload, so that a slow receiver is not overrun.

Top module: `byte_datagram_packer`

## Requirements
- R1: A write (`in_wr` high) is accepted on a rising edge when `in_busy` is low. `in_busy` is high exactly while the 9-bit queue holds `FIFO_DEPTH` entries. A write while `in_busy` is high is ignored and never appears on the output.
- R2: Accepted bytes leave on `out_data` in the order written, with none lost and none duplicated.
- R3: With no flush-tagged byte, a payload is emitted only once it holds `MAX_LEN` bytes, and it then holds exactly `MAX_LEN` bytes.
- R4: A byte written with `in_flush` = 1 closes the current payload at once. It is that payload's final byte and carries `out_last` = 1.
- R5: A flush-tagged byte arriving while the payload is empty gives a 1-byte payload. No zero-length payload is ever emitted.
- R6: `out_len` equals the number of beats in the current payload. It is valid from the first beat, constant to the last, and lies within 1..`MAX_LEN`. `out_last` is high on the beat whose index is `out_len`-1.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_last` and `out_len` hold their values on the next cycle.
- R8: After the last beat of a payload is accepted, `out_valid` stays low for at least `gap_cycles` cycles. If the next payload is already buffered, it rises on exactly cycle `gap_cycles`+1, or on the next cycle when `gap_cycles` is 0.
- R9: Two complete payloads can be held at once. With the output stalled, 2*`MAX_LEN`+`FIFO_DEPTH` bytes are accepted before `in_busy` rises.
- R10: Synchronous active-high `rst` empties the queue, discards any partial payload and both banks, and clears the gap counter. `out_valid` and `in_busy` are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Byte from the producer |
| in_flush | input | 1 | Flush tag for `in_data` |
| in_wr | input | 1 | Write strobe |
| in_busy | output | 1 | Queue full; writes are ignored |
| gap_cycles | input | GAP_W | Minimum idle cycles after each payload |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Final byte of the payload |
| out_len | output | LEN_W | Payload length in bytes, LEN_W = clog2(MAX_LEN+1) |

## Verification
The bench builds the block with `MAX_LEN` = 8, `FIFO_DEPTH` = 4 and `GAP_W` = 8. With these values a full payload needs only eight writes. Both banks plus the queue fill after twenty bytes, so the busy threshold, a write ignored while busy, and the drain order of a full backlog can all be reached in a few hundred cycles. The 8-bit gap allows both exact short gaps (0 and 3) and a long gap of 200 cycles. The long gap shows that a reset partway through the gap cuts it short.

// File: rtl/pkt_pkg.sv
package pkt_pkg;

    localparam int BYTE_W    = 8;
    localparam int TAG_W     = BYTE_W + 1;
    localparam int NUM_BANKS = 2;

    typedef struct packed {
        logic              flush;
        logic [BYTE_W-1:0] data;
    } tagged_byte_t;

    typedef enum logic {
        OS_READY = 1'b0,
        OS_GAP   = 1'b1
    } out_state_t;

    function automatic int len_width(input int max_len);
        return $clog2(max_len + 1);
    endfunction

endpackage

// File: rtl/pkt_tag_fifo.sv
module pkt_tag_fifo
    import pkt_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  tagged_byte_t wr_data,
    output logic         full,
    input  logic         rd_en,
    output tagged_byte_t rd_data,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    tagged_byte_t     store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             push;
    logic             pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push    = wr_en && !full;
    assign pop     = rd_en && !empty;
    assign rd_data = store[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH)); // R1

    AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !rd_en) |=> (count == $past(count)) && (wr_ptr == $past(wr_ptr))); // R1

endmodule

// File: rtl/pkt_assembler.sv
module pkt_assembler
    import pkt_pkg::*;
#(
    parameter int MAX_LEN = 1024,
    parameter int LEN_W   = 11,
    parameter int ADDR_W  = 11
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             fifo_empty,
    input  tagged_byte_t                     fifo_q,
    output logic                             fifo_rd,
    input  logic                             rel_valid,
    input  logic                             rel_bank,
    input  logic [ADDR_W-1:0]                rd_addr,
    output logic [BYTE_W-1:0]                rd_data,
    output logic [NUM_BANKS-1:0]             bank_full,
    output logic [NUM_BANKS-1:0][LEN_W-1:0]  bank_len
);
    localparam int STORE_N = NUM_BANKS * MAX_LEN;

    logic [BYTE_W-1:0] store [STORE_N];
    logic              wb;
    logic [LEN_W-1:0]  fill;
    logic              close;
    logic [ADDR_W-1:0] wr_addr;

    assign fifo_rd = !fifo_empty && !bank_full[wb];
    assign close   = fifo_rd && (fifo_q.flush || (fill == LEN_W'(MAX_LEN - 1)));
    assign wr_addr = wb ? (ADDR_W'(MAX_LEN) + ADDR_W'(fill)) : ADDR_W'(fill);
    assign rd_data = store[rd_addr];

    always_ff @(posedge clk) begin
        if (fifo_rd) store[wr_addr] <= fifo_q.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wb   <= 1'b0;
            fill <= '0;
        end else if (fifo_rd) begin
            if (close) begin
                wb   <= ~wb;
                fill <= '0;
            end else begin
                fill <= fill + LEN_W'(1);
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                bank_full[b] <= 1'b0;
                bank_len[b]  <= '0;
            end else if (close && (wb == 1'(b))) begin
                bank_full[b] <= 1'b1;
                bank_len[b]  <= fill + LEN_W'(1);
            end else if (rel_valid && (rel_bank == 1'(b))) begin
                bank_full[b] <= 1'b0;
            end
        end
    end

    AST_FILL_BELOW_MAX: assert property (@(posedge clk) disable iff (rst)
        fill < LEN_W'(MAX_LEN)); // R3

    AST_CLOSE_ON_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (fifo_rd && fifo_q.flush) |=> bank_full[$past(wb)] && (fill == '0)); // R4

endmodule

// File: rtl/pkt_emitter.sv
module pkt_emitter
    import pkt_pkg::*;
#(
    parameter int MAX_LEN = 1024,
    parameter int LEN_W   = 11,
    parameter int ADDR_W  = 11,
    parameter int GAP_W   = 16
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_BANKS-1:0]            bank_full,
    input  logic [NUM_BANKS-1:0][LEN_W-1:0] bank_len,
    input  logic [BYTE_W-1:0]               rd_data,
    output logic [ADDR_W-1:0]               rd_addr,
    output logic                            rel_valid,
    output logic                            rel_bank,
    input  logic [GAP_W-1:0]                gap_cycles,
    output logic                            out_valid,
    input  logic                            out_ready,
    output logic [BYTE_W-1:0]               out_data,
    output logic                            out_last,
    output logic [LEN_W-1:0]                out_len
);
    out_state_t       state;
    logic             rb;
    logic [LEN_W-1:0] idx;
    logic [GAP_W-1:0] gap_cnt;
    logic             beat;

    assign out_valid = (state == OS_READY) && bank_full[rb];
    assign out_len   = bank_len[rb];
    assign out_last  = (idx == (bank_len[rb] - LEN_W'(1)));
    assign out_data  = rd_data;
    assign rd_addr   = rb ? (ADDR_W'(MAX_LEN) + ADDR_W'(idx)) : ADDR_W'(idx);
    assign beat      = out_valid && out_ready;
    assign rel_valid = beat && out_last;
    assign rel_bank  = rb;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= OS_READY;
            rb      <= 1'b0;
            idx     <= '0;
            gap_cnt <= '0;
        end else begin
            case (state)
                OS_READY: begin
                    if (beat) begin
                        if (out_last) begin
                            idx <= '0;
                            rb  <= ~rb;
                            if (gap_cycles != '0) begin
                                state   <= OS_GAP;
                                gap_cnt <= gap_cycles;
                            end
                        end else begin
                            idx <= idx + LEN_W'(1);
                        end
                    end
                end
                OS_GAP: begin
                    if (gap_cnt == GAP_W'(1)) begin
                        state   <= OS_READY;
                        gap_cnt <= '0;
                    end else begin
                        gap_cnt <= gap_cnt - GAP_W'(1);
                    end
                end
                default: state <= OS_READY;
            endcase
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data)
            && $stable(out_last) && $stable(out_len)); // R7

    AST_GAP_LOW: assert property (@(posedge clk) disable iff (rst)
        (rel_valid && (gap_cycles != '0)) |=> !out_valid); // R8

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_len >= LEN_W'(1)) && (out_len <= LEN_W'(MAX_LEN))); // R6

endmodule

// File: rtl/byte_datagram_packer.sv
module byte_datagram_packer
    import pkt_pkg::*;
#(
    parameter int MAX_LEN    = 1024,
    parameter int FIFO_DEPTH = 16,
    parameter int GAP_W      = 16,
    parameter int LEN_W      = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       in_data,
    input  logic             in_flush,
    input  logic             in_wr,
    output logic             in_busy,
    input  logic [GAP_W-1:0] gap_cycles,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic [LEN_W-1:0] out_len
);
    localparam int ADDR_W = $clog2(NUM_BANKS * MAX_LEN);

    tagged_byte_t                    wr_word;
    tagged_byte_t                    fifo_q;
    logic                            fifo_empty;
    logic                            fifo_rd;
    logic                            rel_valid;
    logic                            rel_bank;
    logic [ADDR_W-1:0]               rd_addr;
    logic [BYTE_W-1:0]               rd_data;
    logic [NUM_BANKS-1:0]            bank_full;
    logic [NUM_BANKS-1:0][LEN_W-1:0] bank_len;

    assign wr_word.flush = in_flush;
    assign wr_word.data  = in_data;

    pkt_tag_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (in_wr),
        .wr_data (wr_word),
        .full    (in_busy),
        .rd_en   (fifo_rd),
        .rd_data (fifo_q),
        .empty   (fifo_empty)
    );

    pkt_assembler #(
        .MAX_LEN (MAX_LEN),
        .LEN_W   (LEN_W),
        .ADDR_W  (ADDR_W)
    ) u_asm (
        .clk        (clk),
        .rst        (rst),
        .fifo_empty (fifo_empty),
        .fifo_q     (fifo_q),
        .fifo_rd    (fifo_rd),
        .rel_valid  (rel_valid),
        .rel_bank   (rel_bank),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .bank_full  (bank_full),
        .bank_len   (bank_len)
    );

    pkt_emitter #(
        .MAX_LEN (MAX_LEN),
        .LEN_W   (LEN_W),
        .ADDR_W  (ADDR_W),
        .GAP_W   (GAP_W)
    ) u_emit (
        .clk        (clk),
        .rst        (rst),
        .bank_full  (bank_full),
        .bank_len   (bank_len),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .rel_valid  (rel_valid),
        .rel_bank   (rel_bank),
        .gap_cycles (gap_cycles),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_last   (out_last),
        .out_len    (out_len)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !out_valid && !in_busy); // R10

endmodule

// File: tb/byte_datagram_packer_tb_top.sv
module byte_datagram_packer_tb_top;
    localparam int MAX_LEN    = 8;
    localparam int FIFO_DEPTH = 4;
    localparam int GAP_W      = 8;
    localparam int LEN_W      = $clog2(MAX_LEN + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [7:0]       in_data = '0;
    logic             in_flush = 1'b0;
    logic             in_wr = 1'b0;
    logic             in_busy;
    logic [GAP_W-1:0] gap_cycles = '0;
    logic             out_valid;
    logic             out_ready = 1'b0;
    logic [7:0]       out_data;
    logic             out_last;
    logic [LEN_W-1:0] out_len;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;
    bit stalled  = 0;

    logic [7:0] rx_q[$];
    int         len_q[$];
    int         gap_q[$];

    always #2 clk = ~clk;

    byte_datagram_packer #(
        .MAX_LEN    (MAX_LEN),
        .FIFO_DEPTH (FIFO_DEPTH),
        .GAP_W      (GAP_W)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_data    (in_data),
        .in_flush   (in_flush),
        .in_wr      (in_wr),
        .in_busy    (in_busy),
        .gap_cycles (gap_cycles),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .out_last   (out_last),
        .out_len    (out_len)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FIL%s %s: actual %0d expected %0d", "", req, act, exp);
        end
    endtask

    // beat monitor, sampled at the falling edge
    int         beats = 0;
    int         pkt_len = 0;
    bit         gapping = 0;
    int         gcnt = 0;
    bit         held = 0;
    logic [7:0] held_data;
    logic [LEN_W-1:0] held_len;
    always @(negedge clk) begin
        if (rst) begin
            beats = 0; gapping = 0; held = 0;
        end else begin
            if (held) begin
                check(out_valid && out_data == held_data && out_len == held_len,
                      "R7 hold", int'(out_data), int'(held_data));
                held = 0;
            end
            if (gapping) begin
                if (out_valid) begin gap_q.push_back(gcnt); gapping = 0; end
                else gcnt++;
            end
            if (out_valid && !out_ready) begin
                held = 1; held_data = out_data; held_len = out_len;
            end
            if (out_valid && out_ready) begin
                if (beats == 0) pkt_len = int'(out_len);
                else check(int'(out_len) == pkt_len, "R6 len stable", int'(out_len), pkt_len);
                rx_q.push_back(out_data);
                beats++;
                check(out_last == (beats == pkt_len), "R6 last position", int'(out_last), int'(beats == pkt_len));
                if (out_last) begin
                    len_q.push_back(beats);
                    beats = 0; gapping = 1; gcnt = 0;
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic send_byte(input logic [7:0] d, input bit fl);
        tick();
        while (in_busy) begin stalled = 1; tick(); end
        in_data = d; in_flush = fl; in_wr = 1'b1;
        tick();
        in_wr = 1'b0; in_flush = 1'b0;
    endtask

    task automatic clear_q();
        rx_q.delete(); len_q.delete(); gap_q.delete(); gapping = 0;
    endtask

    task automatic wait_packets(input int n);
        for (int k = 0; k < 2000 && len_q.size() < n; k++) tick();
    endtask

    task automatic do_reset();
        tick(); rst = 1'b1; tick(); tick(); rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        tick();
        check(!out_valid, "R10 out_valid after reset", int'(out_valid), 0);
        check(!in_busy, "R10 in_busy after reset", int'(in_busy), 0);
    endtask

    task automatic t_single_flush();
        clear_q(); out_ready = 1'b1;
        send_byte(8'hA5, 1'b1);
        wait_packets(1);
        check(len_q.size() == 1 && len_q[0] == 1, "R5 one-byte payload", len_q.size() ? len_q[0] : 0, 1);
        check(rx_q.size() == 1 && rx_q[0] == 8'hA5, "R4 flush byte carried", rx_q.size() ? int'(rx_q[0]) : -1, 8'hA5);
    endtask

    task automatic t_full_no_flush();
        clear_q(); out_ready = 1'b1;
        for (int i = 0; i < MAX_LEN - 1; i++) send_byte(8'(8'h10 + i), 1'b0);
        repeat (10) tick();
        check(len_q.size() == 0 && !out_valid, "R3 no early payload", len_q.size(), 0);
        send_byte(8'h17, 1'b0);
        wait_packets(1);
        check(len_q.size() == 1 && len_q[0] == MAX_LEN, "R3 full payload length", len_q.size() ? len_q[0] : 0, MAX_LEN);
        for (int i = 0; i < MAX_LEN; i++)
            check(rx_q.size() > i && rx_q[i] == 8'(8'h10 + i), "R2 full payload order",
                  rx_q.size() > i ? int'(rx_q[i]) : -1, 8'h10 + i);
    endtask

    task automatic t_flush_mid();
        clear_q(); out_ready = 1'b1;
        send_byte(8'h31, 1'b0); send_byte(8'h32, 1'b0); send_byte(8'h33, 1'b1);
        wait_packets(1);
        check(len_q.size() == 1 && len_q[0] == 3, "R4 flush closes partial", len_q.size() ? len_q[0] : 0, 3);
        check(rx_q.size() == 3 && rx_q[2] == 8'h33, "R4 flush byte last", rx_q.size() == 3 ? int'(rx_q[2]) : -1, 8'h33);
    endtask

    task automatic t_backlog();
        int total;
        clear_q(); out_ready = 1'b0; stalled = 0;
        total = 2 * MAX_LEN + FIFO_DEPTH;
        for (int i = 0; i < total; i++) send_byte(8'(8'h40 + i), 1'b0);
        check(!stalled, "R9 capacity before busy", int'(stalled), 0);
        tick(); tick();
        check(in_busy, "R1 busy when queue full", int'(in_busy), 1);
        in_data = 8'hEE; in_flush = 1'b1; in_wr = 1'b1;
        tick();
        in_wr = 1'b0; in_flush = 1'b0;
        out_ready = 1'b1;
        send_byte(8'h55, 1'b1);
        wait_packets(3);
        check(len_q.size() == 3, "R9 packets from backlog", len_q.size(), 3);
        if (len_q.size() == 3) begin
            check(len_q[0] == MAX_LEN && len_q[1] == MAX_LEN, "R3 backlog full sizes", len_q[1], MAX_LEN);
            check(len_q[2] == FIFO_DEPTH + 1, "R4 backlog tail", len_q[2], FIFO_DEPTH + 1);
        end
        check(rx_q.size() == total + 1, "R1 busy write ignored", rx_q.size(), total + 1);
        for (int i = 0; i < total; i++)
            check(rx_q.size() > i && rx_q[i] == 8'(8'h40 + i), "R2 backlog order",
                  rx_q.size() > i ? int'(rx_q[i]) : -1, 8'h40 + i);
        if (rx_q.size() == total + 1)
            check(rx_q[total] == 8'h55, "R1 after ignored write", int'(rx_q[total]), 8'h55);
    endtask

    task automatic t_gap(input int g);
        clear_q(); out_ready = 1'b0; gap_cycles = GAP_W'(g);
        for (int i = 0; i < 2 * MAX_LEN; i++) send_byte(8'(i), 1'b0);
        out_ready = 1'b1;
        wait_packets(2);
        repeat (2) tick();
        check(gap_q.size() >= 1 && gap_q[0] == g, "R8 exact gap", gap_q.size() ? gap_q[0] : -1, g);
        gap_cycles = '0;
    endtask

    task automatic t_backpressure();
        clear_q(); out_ready = 1'b0;
        for (int i = 0; i < 5; i++) send_byte(8'(8'h60 + i), i == 4);
        for (int k = 0; k < 40; k++) begin
            out_ready = (k % 3) != 0;
            tick();
        end
        out_ready = 1'b1;
        wait_packets(1);
        check(len_q.size() == 1 && len_q[0] == 5, "R6 length under stall", len_q.size() ? len_q[0] : 0, 5);
        for (int i = 0; i < 5; i++)
            check(rx_q.size() > i && rx_q[i] == 8'(8'h60 + i), "R7 data under stall",
                  rx_q.size() > i ? int'(rx_q[i]) : -1, 8'h60 + i);
    endtask

    task automatic t_reset_mid();
        clear_q(); out_ready = 1'b1; gap_cycles = 8'd200;
        send_byte(8'h01, 1'b1);
        wait_packets(1);
        send_byte(8'h02, 1'b0); send_byte(8'h03, 1'b0);
        do_reset();
        gap_cycles = '0;
        clear_q();
        send_byte(8'h77, 1'b1);
        repeat (6) tick();
        check(len_q.size() == 1 && len_q[0] == 1, "R10 partial discarded, gap cleared",
              len_q.size() ? len_q[0] : 0, 1);
        check(rx_q.size() == 1 && rx_q[0] == 8'h77, "R10 fresh payload data",
              rx_q.size() ? int'(rx_q[0]) : -1, 8'h77);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        t_reset_state();
        t_single_flush();
        t_full_no_flush();
        t_flush_mid();
        t_backlog();
        t_gap(3);
        t_gap(0);
        t_backpressure();
        t_reset_mid();
        repeat (4) tick();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

endmodule